// File: doc/BRIEF.md
# Serial Word Buffer with Three-Wire Host Handshake

The block sits behind a frequency-shift-keyed receiver whose demodulated output is an asynchronous serial bit stream (1 for mark, 0 for space). It presents that stream to a microcontroller over three wires: a data output, an active-low data-ready strobe and a read clock that the host drives. The read clock is asynchronous to the system clock.

A mode input picks one of two behaviours. In pass-through mode the raw bit stream goes straight to the data output. In buffered mode the block frames each character with a 16x oversampling tick. It keeps the eight data bits and the stop bit, drops the start bit, and pulses data-ready low. The host then shifts the bits out with read-clock edges. The first read-clock edge during the strobe ends the strobe, so the host can use it as an interrupt that clears when the host reads.

The active-low carrier-detect input gates the whole receive path. A character that is still in progress when the carrier drops is discarded. A word that completes before the host has read the previous one replaces it and sets a sticky overrun flag.

Top module: `fsk_word_buf`

## Requirements
- R1: With `mode_i` low and carrier present (`cd_ni` low), `data_o` follows `rx_bit_i` combinationally.
- R2: With `mode_i` high, a received character is stored as data bit k in buffer position k (least significant bit first, in reception order), with the stop bit in position 8, and the start bit is not stored.
- R3: `dr_no` is high after reset and between words. After every completed character, in both modes, it goes low one clock after the stop bit is sampled and stays low for 8 oversampling ticks (half a bit period).
- R4: In buffered mode, read-clock rising edges 1 through 8 present data bits 0 through 7 on `data_o`. Each bit appears two system clocks after the edge is sampled and holds until the next edge.
- R5: In buffered mode, the 9th read-clock rising edge presents the received stop bit on `data_o`, including a 0 stop bit (framing error).
- R6: In buffered mode, a read-clock rising edge while `dr_no` is low returns `dr_no` high within two system clocks of being sampled, ahead of the half-bit timeout.
- R7: While `cd_ni` is high, no character is received, no strobe is produced, and in pass-through mode `data_o` is held at 1 (mark).
- R8: If `cd_ni` goes high in the middle of a character, the character is discarded without a strobe, and the next character after carrier returns is received normally.
- R9: In buffered mode, a word that completes before the previous word's 9 reads are done replaces the buffer and sets `overrun_o`. `overrun_o` stays set until reset.
- R10: A low pulse on `rx_bit_i` that is high again at the centre of the start bit (8 ticks after the falling edge) is rejected, and no character or strobe follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| os_tick_i | input | 1 | One-cycle tick at 16 times the bit rate |
| rx_bit_i | input | 1 | Demodulated serial bit, 1 = mark |
| cd_ni | input | 1 | Carrier detect, active low |
| mode_i | input | 1 | 0 = pass-through, 1 = buffered |
| rd_clk_i | input | 1 | Host read clock, asynchronous |
| data_o | output | 1 | Data to host |
| dr_no | output | 1 | Data-ready strobe, active low |
| overrun_o | output | 1 | Sticky overrun flag |

## Verification
The bench sends characters whose bit patterns have alternating halves and mixed nibbles (0x3C, 0x5A, 0xC3, 0xA5). These patterns separate an LSB-first buffer from an MSB-first one and a correct shift from an off-by-one shift. Stop bits of 1 and 0 show whether the 9th read returns the real stop bit or a constant. Three more patterns are sent: a short low glitch, a character cut off by carrier loss, and a character sent with no carrier. Together they show that only properly framed characters with carrier produce a strobe. Two words sent back to back with no reads show whether the later word overwrites the buffer and whether the overrun flag stays set. A read-clock edge issued during the strobe tells the early strobe clear apart from the timed half-bit end.

// File: rtl/fsk_buf_pkg.sv
package fsk_buf_pkg;
  typedef enum logic [1:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_STOP
  } rx_state_e;
endpackage

// File: rtl/fsk_edge_sync.sv
module fsk_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic rise_o
);
  // chain[STAGES-1] is the synchronised level, chain[STAGES] its previous value
  logic [STAGES:0] chain;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain <= '0;
    else         chain <= {chain[STAGES-1:0], async_i};
  end

  assign rise_o = chain[STAGES-1] & ~chain[STAGES];
endmodule

// File: rtl/fsk_rx_framer.sv
module fsk_rx_framer
  import fsk_buf_pkg::*;
#(
  parameter int OS_RATE = 16,
  parameter int DATA_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              rx_i,
  input  logic              cd_ni,
  output logic [DATA_W:0]   word_o,
  output logic              word_vld_o
);
  localparam int CNT_W = $clog2(OS_RATE);
  localparam int BIT_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] HALF_M1  = CNT_W'(OS_RATE / 2 - 1);
  localparam logic [CNT_W-1:0] FULL_M1  = CNT_W'(OS_RATE - 1);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(DATA_W - 1);

  rx_state_e        state;
  logic [CNT_W-1:0] os_cnt;
  logic [BIT_W-1:0] bit_cnt;
  logic [DATA_W:0]  shreg;
  logic             rx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state      <= RX_IDLE;
      os_cnt     <= '0;
      bit_cnt    <= '0;
      shreg      <= '0;
      rx_q       <= 1'b1;
      word_o     <= '0;
      word_vld_o <= 1'b0;
    end else begin
      word_vld_o <= 1'b0;
      if (tick_i) rx_q <= rx_i;
      if (cd_ni) begin
        state <= RX_IDLE;  // carrier lost: drop any partial character
      end else if (tick_i) begin
        unique case (state)
          RX_IDLE: if (rx_q && !rx_i) begin
            state  <= RX_START;
            os_cnt <= '0;
          end
          RX_START: begin
            if (os_cnt == HALF_M1) begin
              state   <= rx_i ? RX_IDLE : RX_DATA;
              os_cnt  <= '0;
              bit_cnt <= '0;
            end else os_cnt <= os_cnt + 1'b1;
          end
          RX_DATA: begin
            if (os_cnt == FULL_M1) begin
              os_cnt <= '0;
              shreg  <= {rx_i, shreg[DATA_W:1]};
              if (bit_cnt == LAST_BIT) state <= RX_STOP;
              else bit_cnt <= bit_cnt + 1'b1;
            end else os_cnt <= os_cnt + 1'b1;
          end
          RX_STOP: begin
            if (os_cnt == FULL_M1) begin
              os_cnt     <= '0;
              word_o     <= {rx_i, shreg[DATA_W:1]};
              word_vld_o <= 1'b1;
              state      <= RX_IDLE;
            end else os_cnt <= os_cnt + 1'b1;
          end
          default: state <= RX_IDLE;
        endcase
      end
    end
  end

  // R8
  abort_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cd_ni |=> (state == RX_IDLE && !word_vld_o));

  // R2
  vld_after_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_vld_o |-> $past(state) == RX_STOP);
endmodule

// File: rtl/fsk_word_out.sv
module fsk_word_out #(
  parameter int OS_RATE = 16,
  parameter int DATA_W  = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            tick_i,
  input  logic            mode_i,
  input  logic            rd_rise_i,
  input  logic [DATA_W:0] word_i,
  input  logic            word_vld_i,
  output logic            bit_o,
  output logic            dr_no,
  output logic            overrun_o
);
  localparam int CNT_W = $clog2(OS_RATE);
  localparam int RD_W  = $clog2(DATA_W + 2);
  localparam logic [CNT_W-1:0] DR_LAST  = CNT_W'(OS_RATE / 2 - 1);
  localparam logic [RD_W-1:0]  RD_STOP  = RD_W'(DATA_W);
  localparam logic [RD_W-1:0]  RD_DONE  = RD_W'(DATA_W + 1);

  logic [DATA_W:0]  shbuf;
  logic [RD_W-1:0]  rd_cnt;
  logic             pending;
  logic [CNT_W-1:0] dr_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shbuf     <= '1;
      bit_o     <= 1'b1;
      rd_cnt    <= RD_DONE;
      pending   <= 1'b0;
      overrun_o <= 1'b0;
    end else if (word_vld_i) begin
      shbuf   <= word_i;
      rd_cnt  <= '0;
      pending <= mode_i;
      if (mode_i && pending) overrun_o <= 1'b1;
    end else if (mode_i && rd_rise_i) begin
      bit_o <= shbuf[0];
      shbuf <= {1'b1, shbuf[DATA_W:1]};
      if (rd_cnt == RD_STOP) pending <= 1'b0;
      if (rd_cnt != RD_DONE) rd_cnt <= rd_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dr_no  <= 1'b1;
      dr_cnt <= '0;
    end else if (word_vld_i) begin
      dr_no  <= 1'b0;
      dr_cnt <= '0;
    end else if (!dr_no) begin
      if (mode_i && rd_rise_i) dr_no <= 1'b1;  // host read clears the strobe
      else if (tick_i) begin
        if (dr_cnt == DR_LAST) dr_no <= 1'b1;
        else dr_cnt <= dr_cnt + 1'b1;
      end
    end
  end

  // R3
  dr_on_word_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_vld_i |=> !dr_no);

  // R6
  dr_early_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i && rd_rise_i && !dr_no && !word_vld_i) |=> dr_no);

  // R9
  ovr_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overrun_o |=> overrun_o);
endmodule

// File: rtl/fsk_word_buf.sv
module fsk_word_buf #(
  parameter int OS_RATE     = 16,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic os_tick_i,
  input  logic rx_bit_i,
  input  logic cd_ni,
  input  logic mode_i,
  input  logic rd_clk_i,
  output logic data_o,
  output logic dr_no,
  output logic overrun_o
);
  logic            rd_rise;
  logic [DATA_W:0] word;
  logic            word_vld;
  logic            buf_bit;

  fsk_edge_sync #(.STAGES(SYNC_STAGES)) u_rd_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i (rd_clk_i),
    .rise_o  (rd_rise)
  );

  fsk_rx_framer #(.OS_RATE(OS_RATE), .DATA_W(DATA_W)) u_framer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (os_tick_i),
    .rx_i       (rx_bit_i),
    .cd_ni      (cd_ni),
    .word_o     (word),
    .word_vld_o (word_vld)
  );

  fsk_word_out #(.OS_RATE(OS_RATE), .DATA_W(DATA_W)) u_out (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (os_tick_i),
    .mode_i     (mode_i),
    .rd_rise_i  (rd_rise),
    .word_i     (word),
    .word_vld_i (word_vld),
    .bit_o      (buf_bit),
    .dr_no      (dr_no),
    .overrun_o  (overrun_o)
  );

  // pass-through is held at mark until carrier is present
  assign data_o = mode_i ? buf_bit : (cd_ni ? 1'b1 : rx_bit_i);
endmodule

// File: tb/fsk_word_buf_tb.sv
`timescale 1ns/100ps
module fsk_word_buf_tb;
  logic clk = 1'b0, rst_n = 1'b0, os_tick = 1'b0, rx_bit = 1'b1;
  logic cd_n = 1'b1, mode = 1'b0, rd_clk = 1'b0;
  logic data, dr_n, ovr;
  int errors = 0, checks = 0;
  int dr_falls = 0, run_len = 0, last_low = 0;
  logic prev_dr = 1'b1;

  always #2.5 clk = ~clk;

  fsk_word_buf u_dut (
    .clk_i(clk), .rst_ni(rst_n), .os_tick_i(os_tick), .rx_bit_i(rx_bit),
    .cd_ni(cd_n), .mode_i(mode), .rd_clk_i(rd_clk),
    .data_o(data), .dr_no(dr_n), .overrun_o(ovr)
  );

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference: sample points counted as ticks since the start edge
  bit h1, h2, h3, busy, rxq, vld, m_out, pend, m_dr, m_ovr;
  int ticks, sh, word, bufv, rdcnt, drcnt;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h1 = 0; h2 = 0; h3 = 0; busy = 0; ticks = 0; sh = 0; rxq = 1; vld = 0;
      word = 0; bufv = 511; m_out = 1; rdcnt = 9; pend = 0; m_dr = 1; drcnt = 0; m_ovr = 0;
    end else begin
      bit rise, v0;
      int w0, k;
      rise = h2 && !h3;
      h3 = h2; h2 = h1; h1 = rd_clk;
      v0 = vld; w0 = word; vld = 0;
      if (v0) begin
        if (mode && pend) m_ovr = 1;
        pend = mode; bufv = w0; rdcnt = 0;
      end else if (rise && mode) begin
        m_out = bufv[0];
        bufv = (bufv >> 1) | 256;
        if (rdcnt == 8) pend = 0;
        if (rdcnt < 9) rdcnt++;
      end
      if (v0) begin m_dr = 0; drcnt = 0; end
      else if (!m_dr) begin
        if (mode && rise) m_dr = 1;
        else if (os_tick) begin
          if (drcnt == 7) m_dr = 1; else drcnt++;
        end
      end
      if (cd_n) busy = 0;
      else if (os_tick) begin
        if (!busy) begin
          if (rxq && !rx_bit) begin busy = 1; ticks = 0; sh = 0; end
        end else begin
          ticks++;
          if (ticks == 8) begin
            if (rx_bit) busy = 0;
          end else if (ticks > 8 && (ticks - 8) % 16 == 0) begin
            k = (ticks - 8) / 16;
            if (k <= 8) sh = sh | (int'(rx_bit) << (k - 1));
            else begin word = sh | (int'(rx_bit) << 8); vld = 1; busy = 0; end
          end
        end
      end
      if (os_tick) rxq = rx_bit;
    end
  end

  always @(posedge clk) begin
    #1;
    if (rst_n) begin
      logic md;
      md = mode ? m_out : (cd_n ? 1'b1 : rx_bit);
      chk(data === md, mode ? "R4" : "R1", int'(data), int'(md));
      chk(dr_n === m_dr, "R3", int'(dr_n), int'(m_dr));
      chk(ovr === m_ovr, "R9", int'(ovr), int'(m_ovr));
      if (prev_dr && !dr_n) begin dr_falls++; run_len = 0; end
      if (!dr_n) run_len++;
      if (!prev_dr && dr_n) last_low = run_len;
      prev_dr = dr_n;
    end
  end

  initial begin
    int t = 0;
    forever begin
      @(negedge clk);
      t++;
      os_tick = (t % 4 == 0);
    end
  end

  task automatic wait_clks(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(bit b);
    rx_bit = b;
    wait_clks(64);
  endtask

  task automatic send_word(int b, bit stopb, int drop_at);
    send_bit(1'b0);
    for (int i = 0; i < 8; i++) begin
      if (i == drop_at) cd_n = 1'b1;
      send_bit(b[i]);
    end
    send_bit(stopb);
    rx_bit = 1'b1;
    wait_clks(64);
  endtask

  task automatic rd_pulse();
    rd_clk = 1'b1; wait_clks(4);
    rd_clk = 1'b0; wait_clks(4);
  endtask

  task automatic read_word(output int v);
    v = 0;
    for (int i = 0; i < 9; i++) begin
      rd_pulse();
      v = v | (int'(data) << i);
    end
  endtask

  task automatic wait_dr_low();
    int n = 0;
    while (dr_n && n < 2000) begin @(negedge clk); n++; end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog (all requirements): actual=timeout expected=done");
    finish_run();
  end

  initial begin
    int v, f;
    wait_clks(3);
    rst_n = 1'b1;
    wait_clks(2);
    // reset state: R3 strobe idle, R9 flag clear, R7 mark with no carrier
    chk(dr_n == 1, "R3", int'(dr_n), 1);
    chk(ovr == 0, "R9", int'(ovr), 0);
    chk(data == 1, "R7", int'(data), 1);

    // R7: no carrier, pass-through held at mark, nothing received
    rx_bit = 1'b0; wait_clks(2);
    chk(data == 1, "R7", int'(data), 1);
    rx_bit = 1'b1; wait_clks(10);
    f = dr_falls;
    send_word(8'h0F, 1'b1, -1);
    chk(dr_falls == f, "R7", dr_falls - f, 0);

    // R1: pass-through with carrier
    cd_n = 1'b0; wait_clks(20);
    rx_bit = 1'b0; wait_clks(1);
    chk(data == 0, "R1", int'(data), 0);
    rx_bit = 1'b1; wait_clks(1);
    chk(data == 1, "R1", int'(data), 1);
    // R3: strobe in pass-through mode, half a bit long
    f = dr_falls;
    send_word(8'hA5, 1'b1, -1);
    chk(dr_falls == f + 1, "R3", dr_falls - f, 1);
    chk(last_low >= 28 && last_low <= 33, "R3", last_low, 32);

    // R10: short glitch rejected
    f = dr_falls;
    rx_bit = 1'b0; wait_clks(12);
    rx_bit = 1'b1; wait_clks(300);
    chk(dr_falls == f, "R10", dr_falls - f, 0);

    // R2 R4 R5: buffered mode, normal read-out
    mode = 1'b1; wait_clks(10);
    send_word(8'h3C, 1'b1, -1);
    read_word(v);
    chk((v & 255) == 8'h3C, "R2", v & 255, 8'h3C);
    chk(v[8] == 1, "R5", v[8], 1);
    chk(ovr == 0, "R9", int'(ovr), 0);
    wait_clks(40);
    chk(data == 1, "R4", int'(data), 1);

    // R6: first read edge during strobe clears it early
    fork
      send_word(8'h5A, 1'b1, -1);
      begin
        wait_dr_low();
        rd_clk = 1'b1; wait_clks(4);
        chk(dr_n == 1, "R6", int'(dr_n), 1);
        chk(data == 0, "R4", int'(data), 0);
        rd_clk = 1'b0; wait_clks(4);
      end
    join
    v = 0;
    for (int i = 1; i < 9; i++) begin
      rd_pulse();
      v = v | (int'(data) << i);
    end
    chk(v == 9'h15A, "R4", v, 9'h15A);

    // R5: framing error visible on 9th read
    send_word(8'hC3, 1'b0, -1);
    read_word(v);
    chk(v == 9'h0C3, "R5", v, 9'h0C3);

    // R8: carrier lost mid-character, then recovery
    f = dr_falls;
    send_word(8'h81, 1'b1, 3);
    chk(dr_falls == f, "R8", dr_falls - f, 0);
    cd_n = 1'b0; wait_clks(20);
    send_word(8'h7E, 1'b1, -1);
    read_word(v);
    chk(v == 9'h17E, "R8", v, 9'h17E);

    // R9: overrun on unread word, newest word kept, flag sticky
    send_word(8'h11, 1'b1, -1);
    send_word(8'h22, 1'b1, -1);
    chk(ovr == 1, "R9", int'(ovr), 1);
    read_word(v);
    chk(v == 9'h122, "R9", v, 9'h122);
    send_word(8'h33, 1'b1, -1);
    read_word(v);
    chk(ovr == 1, "R9", int'(ovr), 1);
    chk(v == 9'h133, "R2", v, 9'h133);

    wait_clks(10);
    finish_run();
  end
endmodule